// File: doc/BRIEF.md
# Planar Frame Buffer Write Datapath

This block sits between a host CPU and a frame buffer made of four byte-wide memory planes. A CPU write reaches the same byte offset in all four planes at once. The block turns that one data byte into four plane bytes. How it does so depends on a 2-bit write mode. The mode can pass rotated CPU data through, with a per-plane constant override. It can copy back what the last read returned. It can expand a 4-bit colour under a per-pixel mask. Or it can use masked, rotated CPU data as the mask for a per-plane constant.

Software sets up the block through an index/data register port. The index selects one of the control registers: constant colour, constant enable, rotate count, mode register, a mode-field-only update, and bit mask. Every CPU read of the frame buffer also presents the four plane bytes at the read address. The block keeps a copy of them in four read latches, and later writes merge with that copy. The plane storage itself lives outside the block. The plane data and strobes are combinational from the CPU write inputs, so the external array commits them at the clock edge that ends the write cycle.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset the constant colour, constant enable, rotate count and mode register read 0, the bit mask reads 0xFF, and no plane strobe is active.
- R2: Register indices are 0 constant colour (bits 3:0), 1 constant enable (bits 3:0), 2 rotate count (bits 2:0), 3 mode register (all 8 bits), 4 bit mask (8 bits), and 5 mode-field update. Index 5 reads back the mode register. Bits a register does not hold read as 0, and indices 6 and 7 read 0. The write mode is bits 1:0 of the mode register.
- R3: All four plane strobes are high in exactly the cycle `cpu_wr` is high, and all are low otherwise. Plane n uses bits [8n+7:8n] of `plane_wdata` and of `rd_planes`.
- R4: In mode 0, CPU data is rotated right by the rotate count (0 to 7) before it reaches a plane.
- R5: In mode 0, a plane whose constant-enable bit is 1 receives its constant-colour bit copied to all 8 bits, in place of the rotated data.
- R6: In modes 0 and 2, a bit-mask bit of 0 makes that bit position of every plane take the value of the plane's read latch.
- R7: In mode 1, each plane is written with its own read latch, unchanged.
- R8: The read latches load `rd_planes` at the clock edge that ends a cycle with `cpu_rd` high. They hold their value through all other cycles, writes included.
- R9: In mode 2, bit n of the low 4 bits of CPU data is copied to every masked-in bit of plane n.
- R10: In mode 3, the rotated CPU data ANDed with the bit mask forms the mask. Where it is 1 a plane takes its constant-colour bit, and where it is 0 it takes its latch bit. The constant-enable register is not used.
- R11: A write to index 5 replaces only bits 1:0 of the mode register and keeps bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the indexed register (combinational) |
| cpu_rd | input | 1 | Frame-buffer read cycle; `rd_planes` is valid |
| rd_planes | input | 32 | Four plane bytes at the read address |
| cpu_wr | input | 1 | Frame-buffer write cycle |
| cpu_wdata | input | 8 | CPU write data |
| plane_wdata | output | 32 | Data for the four planes |
| plane_we | output | 4 | Write strobe for each plane |

## Verification
Plane data, plane strobes and register read-back are combinational. The bench samples them 1 ns after it drives the inputs on the falling edge, within the same cycle. Register writes and read-latch loads take effect at the next rising edge. The bench therefore updates its reference model only after that edge, and samples the results again from the following falling edge onward. The bench compares a mode 1 write against the model's latch copy, so any early, late or spurious latch load shows up as a mismatch in plane data.

// File: rtl/vpw_pkg.sv
// Package: shared register indices and write-mode encoding for the
// planar write datapath. Assumes a 3-bit register index.
package vpw_pkg;
    localparam int IDXW = 3;

    localparam logic [IDXW-1:0] IDX_CONST   = 3'd0;
    localparam logic [IDXW-1:0] IDX_CEN     = 3'd1;
    localparam logic [IDXW-1:0] IDX_ROT     = 3'd2;
    localparam logic [IDXW-1:0] IDX_MODE    = 3'd3;
    localparam logic [IDXW-1:0] IDX_MASK    = 3'd4;
    localparam logic [IDXW-1:0] IDX_MODEFLD = 3'd5;

    typedef enum logic [1:0] {
        WM_DIRECT  = 2'd0,
        WM_LATCH   = 2'd1,
        WM_COLOUR  = 2'd2,
        WM_SETMASK = 2'd3
    } wmode_e;
endpackage

// File: rtl/vpw_regs.sv
// Module: control register file behind an index/data port.
// Assumes DW >= PLANES and DW >= 2; a write takes effect at the next edge,
// and read-back is combinational.
module vpw_regs
    import vpw_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PLANES = 4,
    parameter int RW     = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [IDXW-1:0] reg_idx,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [PLANES-1:0] const_q,
    output logic [PLANES-1:0] cen_q,
    output logic [RW-1:0]   rot_q,
    output logic [DW-1:0]   mode_q,
    output logic [DW-1:0]   bm_q
);
    localparam logic [DW-1:0] MASK_RST = '1;

    // Register update on an indexed write; index 5 replaces only the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            const_q <= '0;
            cen_q   <= '0;
            rot_q   <= '0;
            mode_q  <= '0;
            bm_q    <= MASK_RST;
        end else if (reg_wr) begin
            case (reg_idx)
                IDX_CONST:   const_q <= reg_wdata[PLANES-1:0];
                IDX_CEN:     cen_q   <= reg_wdata[PLANES-1:0];
                IDX_ROT:     rot_q   <= reg_wdata[RW-1:0];
                IDX_MODE:    mode_q  <= reg_wdata;
                IDX_MASK:    bm_q    <= reg_wdata;
                IDX_MODEFLD: mode_q  <= {mode_q[DW-1:2], reg_wdata[1:0]};
                default:     ;
            endcase
        end
    end

    // Read-back mux with zero fill of unheld bits.
    always_comb begin
        case (reg_idx)
            IDX_CONST:   reg_rdata = {{(DW-PLANES){1'b0}}, const_q};
            IDX_CEN:     reg_rdata = {{(DW-PLANES){1'b0}}, cen_q};
            IDX_ROT:     reg_rdata = {{(DW-RW){1'b0}}, rot_q};
            IDX_MODE,
            IDX_MODEFLD: reg_rdata = mode_q;
            IDX_MASK:    reg_rdata = bm_q;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vpw_latch.sv
// Module: read latches holding one byte per plane from the latest CPU read.
// Assumes rd_planes is valid in any cycle where cpu_rd is high.
module vpw_latch #(
    parameter int DW     = 8,
    parameter int PLANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_rd,
    input  logic [PLANES*DW-1:0] rd_planes,
    output logic [PLANES*DW-1:0] latch_q
);
    // Capture all planes at the edge that ends a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (cpu_rd) latch_q <= rd_planes;
    end
endmodule

// File: rtl/vpw_merge.sv
// Module: combinational per-plane write data builder. It rotates the CPU
// byte once, then one lane per plane picks a source and a mask by mode
// and merges the source with that plane's latch byte.
module vpw_merge
    import vpw_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PLANES = 4,
    parameter int RW     = $clog2(DW)
) (
    input  logic [1:0]           wmode,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic [RW-1:0]        rot_q,
    input  logic [PLANES-1:0]    const_q,
    input  logic [PLANES-1:0]    cen_q,
    input  logic [DW-1:0]        bm_q,
    input  logic [PLANES*DW-1:0] latch_q,
    output logic [PLANES*DW-1:0] plane_wdata
);
    logic [2*DW-1:0] dbl;
    logic [2*DW-1:0] dbl_sh;
    logic [DW-1:0]   rot_data;

    // Rotate right by doubling the byte and shifting.
    always_comb begin
        dbl      = {cpu_wdata, cpu_wdata};
        dbl_sh   = dbl >> rot_q;
        rot_data = dbl_sh[DW-1:0];
    end

    for (genvar n = 0; n < PLANES; n++) begin : g_lane
        logic [DW-1:0] src;
        logic [DW-1:0] msk;
        logic [DW-1:0] lat;

        assign lat = latch_q[n*DW +: DW];

        // Per-plane source and mask selection by write mode.
        always_comb begin
            case (wmode_e'(wmode))
                WM_DIRECT: begin
                    src = cen_q[n] ? {DW{const_q[n]}} : rot_data;
                    msk = bm_q;
                end
                WM_LATCH: begin
                    src = lat;
                    msk = '1;
                end
                WM_COLOUR: begin
                    src = {DW{cpu_wdata[n]}};
                    msk = bm_q;
                end
                default: begin
                    src = {DW{const_q[n]}};
                    msk = rot_data & bm_q;
                end
            endcase
        end

        assign plane_wdata[n*DW +: DW] = (src & msk) | (lat & ~msk);
    end
endmodule

// File: rtl/vga_plane_writer.sv
// Module: top of the planar write datapath. It ties together the register
// file, the read latches and the merge logic. Plane strobes follow cpu_wr
// in the same cycle; the external plane array commits at the next edge.
module vga_plane_writer
    import vpw_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PLANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDXW-1:0]      reg_idx,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic                 cpu_rd,
    input  logic [PLANES*DW-1:0] rd_planes,
    input  logic                 cpu_wr,
    input  logic [DW-1:0]        cpu_wdata,
    output logic [PLANES*DW-1:0] plane_wdata,
    output logic [PLANES-1:0]    plane_we
);
    localparam int RW = $clog2(DW);

    logic [PLANES-1:0]    const_q;
    logic [PLANES-1:0]    cen_q;
    logic [RW-1:0]        rot_q;
    logic [DW-1:0]        mode_q;
    logic [DW-1:0]        bm_q;
    logic [PLANES*DW-1:0] latch_q;

    vpw_regs #(.DW(DW), .PLANES(PLANES), .RW(RW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .const_q   (const_q),
        .cen_q     (cen_q),
        .rot_q     (rot_q),
        .mode_q    (mode_q),
        .bm_q      (bm_q)
    );

    vpw_latch #(.DW(DW), .PLANES(PLANES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .rd_planes (rd_planes),
        .latch_q   (latch_q)
    );

    vpw_merge #(.DW(DW), .PLANES(PLANES), .RW(RW)) u_merge (
        .wmode       (mode_q[1:0]),
        .cpu_wdata   (cpu_wdata),
        .rot_q       (rot_q),
        .const_q     (const_q),
        .cen_q       (cen_q),
        .bm_q        (bm_q),
        .latch_q     (latch_q),
        .plane_wdata (plane_wdata)
    );

    // All planes are written together on a CPU write.
    assign plane_we = {PLANES{cpu_wr}};
endmodule

// File: rtl/vpw_chk.sv
// Module: assertion checker bound into vga_plane_writer. It watches ports
// and the register, latch and mode state that separate submodules drive.
module vpw_chk
    import vpw_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PLANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDXW-1:0]      reg_idx,
    input  logic [DW-1:0]        reg_wdata,
    input  logic                 cpu_rd,
    input  logic [PLANES*DW-1:0] rd_planes,
    input  logic                 cpu_wr,
    input  logic [PLANES*DW-1:0] plane_wdata,
    input  logic [PLANES-1:0]    plane_we,
    input  logic [PLANES*DW-1:0] latch_q,
    input  logic [DW-1:0]        mode_q,
    input  logic [DW-1:0]        bm_q
);
    // R3
    strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(plane_we) == (cpu_wr ? PLANES : 0));

    // R8
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> latch_q == $past(rd_planes));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(latch_q));

    // R11
    mode_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_MODEFLD) |=>
            (mode_q[DW-1:2] == $past(mode_q[DW-1:2]) &&
             mode_q[1:0] == $past(reg_wdata[1:0])));

    // R7
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && mode_q[1:0] == 2'd1) |-> plane_wdata == latch_q);

    // R6
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !mode_q[0]) |->
            ((plane_wdata ^ latch_q) & ~{PLANES{bm_q}}) == '0);
endmodule

bind vga_plane_writer vpw_chk #(.DW(DW), .PLANES(PLANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .cpu_rd      (cpu_rd),
    .rd_planes   (rd_planes),
    .cpu_wr      (cpu_wr),
    .plane_wdata (plane_wdata),
    .plane_we    (plane_we),
    .latch_q     (latch_q),
    .mode_q      (mode_q),
    .bm_q        (bm_q)
);

// File: tb/vga_plane_writer_tb.sv
// Bench: behavioural reference model of registers, latches and plane
// memory; outputs compared in every driven cycle.
module vga_plane_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cpu_rd = 1'b0;
    logic [31:0] rd_planes = 32'hDEAD_BEEF;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [31:0] plane_wdata;
    logic [3:0]  plane_we;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] mem [4][16];
    int         wr_addr = 0;

    int         m_const = 0, m_cen = 0, m_rot = 0, m_mode = 0, m_bm = 255;
    logic [7:0] m_lat [4];

    always #5 clk = ~clk;

    vga_plane_writer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_rd(cpu_rd),
        .rd_planes(rd_planes), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .plane_wdata(plane_wdata), .plane_we(plane_we)
    );

    // External plane array written by the block's strobes.
    always @(posedge clk) begin
        for (int n = 0; n < 4; n++)
            if (plane_we[n]) mem[n][wr_addr] <= plane_wdata[n*8 +: 8];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_out(input logic [7:0] d);
        logic [31:0] r;
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 8; i++) begin
                bit v, use_it;
                bit rb;
                rb = d[(i + m_rot) % 8];
                v = 0; use_it = 0;
                if (m_mode % 4 == 0) begin
                    v = ((m_cen >> n) & 1) ? bit'((m_const >> n) & 1) : rb;
                    use_it = bit'((m_bm >> i) & 1);
                end else if (m_mode % 4 == 2) begin
                    v = d[n];
                    use_it = bit'((m_bm >> i) & 1);
                end else if (m_mode % 4 == 3) begin
                    v = bit'((m_const >> n) & 1);
                    use_it = rb & bit'((m_bm >> i) & 1);
                end
                r[n*8 + i] = use_it ? v : m_lat[n][i];
            end
        end
        return r;
    endfunction

    task automatic reg_write(input int idx, input int val);
        @(negedge clk);
        reg_wr = 1; reg_idx = 3'(idx); reg_wdata = 8'(val);
        #1 chk(plane_we == 4'h0, "R3 no strobe on register write", 32'(plane_we), 0);
        @(posedge clk); #1;
        reg_wr = 0;
        case (idx)
            0: m_const = val & 15;
            1: m_cen = val & 15;
            2: m_rot = val & 7;
            3: m_mode = val & 255;
            4: m_bm = val & 255;
            5: m_mode = (m_mode & 8'hFC) | (val & 3);
            default: ;
        endcase
    endtask

    task automatic reg_check(input int idx, input int exp, input string tag);
        @(negedge clk);
        reg_idx = 3'(idx);
        #1 chk(reg_rdata == 8'(exp), tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic plane_read(input int addr);
        @(negedge clk);
        cpu_rd = 1;
        rd_planes = {mem[3][addr], mem[2][addr], mem[1][addr], mem[0][addr]};
        @(posedge clk); #1;
        cpu_rd = 0;
        rd_planes = 32'hDEAD_BEEF;
        for (int n = 0; n < 4; n++) m_lat[n] = mem[n][addr];
    endtask

    task automatic plane_write(input int addr, input logic [7:0] d, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        cpu_wr = 1; cpu_wdata = d; wr_addr = addr;
        exp = model_out(d);
        #1;
        chk(plane_wdata == exp, tag, plane_wdata, exp);
        chk(plane_we == 4'hF, "R3 all strobes on write", 32'(plane_we), 32'hF);
        @(posedge clk); #1;
        cpu_wr = 0;
    endtask

    initial begin
        for (int n = 0; n < 4; n++)
            for (int a = 0; a < 16; a++) mem[n][a] = 8'((a * 37 + n * 91 + 5) ^ (n << 6));
        for (int n = 0; n < 4; n++) m_lat[n] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        reg_check(0, 0, "R1 const reset");
        reg_check(1, 0, "R1 enable reset");
        reg_check(2, 0, "R1 rotate reset");
        reg_check(3, 0, "R1 mode reset");
        reg_check(4, 255, "R1 mask reset");
        chk(plane_we == 4'h0, "R1 idle strobes", 32'(plane_we), 0);

        // R11 and R2: mode field update and read-back
        reg_write(3, 8'hA4);
        reg_write(5, 8'hFB);
        reg_check(3, 8'hA7, "R11 mode field update keeps upper bits");
        reg_check(5, 8'hA7, "R2 index 5 reads mode register");
        reg_write(0, 8'hF5);
        reg_check(0, 8'h05, "R2 const holds 4 bits");
        reg_write(2, 8'hFF);
        reg_check(2, 8'h07, "R2 rotate holds 3 bits");
        reg_check(7, 0, "R2 unused index reads 0");
        reg_write(3, 8'h00);
        reg_write(0, 0);

        // R4: mode 0 rotate
        plane_read(1);
        reg_write(2, 3);
        plane_write(1, 8'h96, "R4 rotate by 3");
        plane_write(2, 8'h3C, "R4 rotate by 3 second pattern");
        reg_write(2, 7);
        plane_write(3, 8'h81, "R4 rotate by 7");
        reg_write(2, 0);
        plane_write(4, 8'h5A, "R4 rotate by 0");

        // R5: constant override
        reg_write(1, 4'b0101); reg_write(0, 4'b0011); reg_write(2, 1);
        plane_write(7, 8'hC6, "R5 constant override per plane");

        // R6: bit mask in mode 0 keeps latch bits
        plane_read(9);
        reg_write(4, 8'h0F);
        plane_write(9, 8'h77, "R6 mode 0 masked bits from latch");
        reg_write(4, 8'hFF); reg_write(1, 0);

        // R7, R8: latch copy and hold
        plane_read(2);
        reg_write(5, 1);
        plane_write(10, 8'h00, "R7 latch copy");
        reg_write(5, 0);
        plane_write(11, 8'hE1, "R8 write in mode 0 between");
        reg_write(5, 1);
        plane_write(12, 8'hFF, "R8 latch held across write");
        plane_read(11);
        plane_write(13, 8'h12, "R8 latch loaded from read of written byte");

        // R9: mode 2 colour under mask
        plane_read(3);
        reg_write(5, 2); reg_write(4, 8'h3C);
        plane_write(3, 8'hF6, "R9 colour 6 under mask");
        plane_write(4, 8'h09, "R9 colour 9 under mask");

        // R10: mode 3
        plane_read(5);
        reg_write(5, 3); reg_write(0, 4'b1010); reg_write(2, 2); reg_write(4, 8'hF0);
        reg_write(1, 4'hF);
        plane_write(5, 8'hC3, "R10 masked constant");
        reg_write(4, 8'hFF); reg_write(2, 0);
        plane_write(6, 8'h55, "R10 full mask no rotate");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule